// File: doc/BRIEF.md
# CPU-Cycle Interrupt Up-Counter

This block holds a 15-bit count that climbs by one on every CPU cycle and raises an interrupt once the count reaches its top value, 0x7FFF, while interrupts are enabled. The CPU works on the live count itself, not on a reload value. One register holds the low eight bits. A second register holds the upper seven bits in data bits 6..0 and the interrupt enable in data bit 7. Software can read or rewrite either half at any time, and the count carries on from whatever value was written.

Each register answers anywhere in its own 2 KB window of the CPU map: 0x5000-0x57FF for the low byte and 0x5800-0x5FFF for the high byte. The block sees only address bits 15..11 (`cpu_page`). A CPU cycle is one system clock with `cpu_ce` high. Strobes take effect only in such cycles. The read data is combinational from `cpu_page`, so it needs no handshake and applies no back-pressure. Once the count reaches 0x7FFF it stays there. The interrupt pin is active low. Any read or write of either register clears a pending interrupt.

Top module: `cycle_irq_counter`

## Requirements
- R1: After reset the count is 0x0000, the enable is 0, no interrupt is pending, and `irq_n` is 1.
- R2: In a CPU cycle with no write to either counter register and a count below 0x7FFF, the count rises by exactly one, with carry from bit 7 into bit 8.
- R3: In a clock with `cpu_ce` low, the count and the enable keep their values and the strobes have no effect.
- R4: The count stops at 0x7FFF and does not wrap. It leaves that value only through a register write.
- R5: With `cpu_page` = 5'h0A, `rd_data` shows count bits 7..0. A write to that page loads them from `wr_data`.
- R6: With `cpu_page` = 5'h0B, `rd_data` shows {enable, count bits 14..8}. A write to that page loads count bits 14..8 from `wr_data[6:0]` and the enable from `wr_data[7]` (1 = enabled).
- R7: A write in a CPU cycle replaces that cycle's increment. The half of the count that is not written keeps its value from before the cycle.
- R8: In a CPU cycle with the count at 0x7FFF, the enable at 1 and no register access, the interrupt becomes pending, and `irq_n` is 0 from the following clock. While those conditions hold, it becomes pending again after each acknowledge.
- R9: A read or write of either counter register in a CPU cycle clears the pending interrupt, so `irq_n` is 1 after that edge. Strobes given with `cpu_ce` low do not acknowledge.
- R10: With the enable at 0, `irq_n` stays 1 even when the count sits at 0x7FFF.
- R11: On any other page, `rd_data` is 0x00. Reads and writes there neither acknowledge the interrupt nor alter the count, which goes on counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ce | input | 1 | High for one clock per CPU cycle |
| cpu_page | input | 5 | CPU address bits 15..11 |
| wr_data | input | 8 | CPU write data |
| wr_en | input | 1 | CPU write strobe |
| rd_en | input | 1 | CPU read strobe (acknowledge only) |
| rd_data | output | 8 | Read data for the selected counter register |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench writes and reads back every value of both registers. A design with a swapped bit lane or a misplaced enable bit fails there. It also fails if the other half of the count moves during a write, which shows an increment that was not suppressed. Runs that start just below 0x7FFF check when the interrupt fires. A design that wraps to zero would drop the count, and one that sets the flag a cycle early would pull `irq_n` low too soon. The bench checks acknowledges through each register, strobes given with `cpu_ce` low, and accesses to a foreign page. A design that acknowledges on the wrong qualifier either keeps `irq_n` low or releases it when it should not. Clearing the enable through the high register must release the interrupt and keep it released.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;

  // Which counter register, if any, the current CPU page selects.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } reg_sel_e;

  // Log2 of the span that one register mirrors across (2 KB).
  localparam int SPAN_LOG2 = 11;

  // Base CPU addresses of the two counter windows.
  localparam int LO_BASE = 32'h5000;
  localparam int HI_BASE = 32'h5800;

endpackage

// File: rtl/cyc_irq_decode.sv
module cyc_irq_decode
  import cyc_irq_pkg::*;
#(
  parameter int PAGE_W = 5
) (
  input  logic              cpu_ce,
  input  logic [PAGE_W-1:0] cpu_page,
  input  logic              wr_en,
  input  logic              rd_en,
  output reg_sel_e          sel,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              access
);

  localparam logic [PAGE_W-1:0] LO_PAGE = PAGE_W'(LO_BASE >> SPAN_LOG2);
  localparam logic [PAGE_W-1:0] HI_PAGE = PAGE_W'(HI_BASE >> SPAN_LOG2);

  always_comb begin
    if (cpu_page == LO_PAGE)      sel = SEL_LO;
    else if (cpu_page == HI_PAGE) sel = SEL_HI;
    else                          sel = SEL_NONE;
  end

  // Strobes count only in a CPU cycle.
  assign wr_lo  = cpu_ce && wr_en && (sel == SEL_LO);
  assign wr_hi  = cpu_ce && wr_en && (sel == SEL_HI);
  assign access = cpu_ce && (wr_en || rd_en) && (sel != SEL_NONE);

  // Both counter writes are never asserted together.
  always_comb begin
    a_one_write_r7: assert ($onehot0({wr_lo, wr_hi}));
  end

endmodule

// File: rtl/cyc_irq_count.sv
module cyc_irq_count #(
  parameter int CNT_W  = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ce,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  cnt,
  output logic              en,
  output logic              at_max
);

  localparam int HI_W = CNT_W - DATA_W;
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_nxt;
  logic             en_nxt;

  assign at_max = (cnt == TOP);

  always_comb begin
    cnt_nxt = cnt;
    en_nxt  = en;
    if (wr_lo) begin
      cnt_nxt[DATA_W-1:0] = wr_data;
    end else if (wr_hi) begin
      cnt_nxt[CNT_W-1:DATA_W] = wr_data[HI_W-1:0];
      en_nxt                  = wr_data[DATA_W-1];
    end else if (cpu_ce && !at_max) begin
      cnt_nxt = cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      en  <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      en  <= en_nxt;
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && !wr_lo && !wr_hi && cnt != TOP) |=> (cnt == $past(cnt) + CNT_W'(1)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ce |=> ($stable(cnt) && $stable(en)));

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOP && !wr_lo && !wr_hi) |=> (cnt == TOP));

  p_keep_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> ($stable(cnt[CNT_W-1:DATA_W]) && $stable(en)));

  p_keep_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> $stable(cnt[DATA_W-1:0]));

endmodule

// File: rtl/cyc_irq_flag.sv
module cyc_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_ce,
  input  logic at_max,
  input  logic en,
  input  logic access,
  output logic pending
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (access) begin
      pending <= 1'b0;
    end else if (cpu_ce && at_max && en) begin
      pending <= 1'b1;
    end
  end

  p_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && at_max && en && !access) |=> pending);

  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> !pending);

  p_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> en);

endmodule

// File: rtl/cycle_irq_counter.sv
module cycle_irq_counter
  import cyc_irq_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ce,
  input  logic [PAGE_W-1:0] cpu_page,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_n
);

  reg_sel_e         sel;
  logic             wr_lo;
  logic             wr_hi;
  logic             access;
  logic [CNT_W-1:0] cnt;
  logic             en;
  logic             at_max;
  logic             pending;

  cyc_irq_decode #(.PAGE_W(PAGE_W)) u_decode (
    .cpu_ce   (cpu_ce),
    .cpu_page (cpu_page),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .sel      (sel),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .access   (access)
  );

  cyc_irq_count #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_ce  (cpu_ce),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wr_data (wr_data),
    .cnt     (cnt),
    .en      (en),
    .at_max  (at_max)
  );

  cyc_irq_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_ce  (cpu_ce),
    .at_max  (at_max),
    .en      (en),
    .access  (access),
    .pending (pending)
  );

  always_comb begin
    unique case (sel)
      SEL_LO:  rd_data = cnt[DATA_W-1:0];
      SEL_HI:  rd_data = {en, cnt[CNT_W-1:DATA_W]};
      default: rd_data = '0;
    endcase
  end

  assign irq_n = ~pending;

  p_irq_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && at_max && en && !access) |=> !irq_n);

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> irq_n);

  p_foreign_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (rd_data == '0));

endmodule

// File: tb/cycle_irq_counter_test.sv
module cycle_irq_counter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_ce = 1'b0;
  logic [4:0] cpu_page = 5'h00;
  logic [7:0] wr_data = 8'h00;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq_n;

  int n_checks = 0;
  int n_fails  = 0;

  localparam logic [4:0] PG_LO = 5'h0A;
  localparam logic [4:0] PG_HI = 5'h0B;

  always #5 clk = ~clk;

  cycle_irq_counter uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_ce   (cpu_ce),
    .cpu_page (cpu_page),
    .wr_data  (wr_data),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .irq_n    (irq_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock with the given strobes, then back to idle (cpu_ce low).
  task automatic bus(input logic [4:0] pg, input logic [7:0] d,
                     input logic w, input logic r, input logic ce);
    @(negedge clk);
    cpu_page = pg; wr_data = d; wr_en = w; rd_en = r; cpu_ce = ce;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; cpu_ce = 1'b0;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; cpu_ce = 1'b1;
    repeat (n) @(negedge clk);
    cpu_ce = 1'b0;
  endtask

  // Combinational read with no strobe, sampled between edges.
  task automatic peek(input logic [4:0] pg, output logic [7:0] v);
    cpu_page = pg;
    #1;
    v = rd_data;
  endtask

  task automatic check_count(input string req, input int exp);
    logic [7:0] lo, hi;
    peek(PG_LO, lo);
    peek(PG_HI, hi);
    check(req, {hi[6:0], lo}, exp);
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(PG_LO, v); check("R1 lo", v, 0);
    peek(PG_HI, v); check("R1 hi", v, 0);
    check("R1 irq_n", irq_n, 1);

    // R5 low register sweep, R7 high half untouched
    for (int i = 0; i < 256; i++) begin
      bus(PG_LO, 8'(i), 1'b1, 1'b0, 1'b1);
      peek(PG_LO, v); check("R5 lo readback", v, i);
      peek(PG_HI, v); check("R7 hi kept", v, 0);
    end

    // R6 high register sweep, R7 low half untouched (stays 0xFF)
    for (int i = 0; i < 256; i++) begin
      bus(PG_HI, 8'(i), 1'b1, 1'b0, 1'b1);
      peek(PG_HI, v); check("R6 hi readback", v, i);
      peek(PG_LO, v); check("R7 lo kept", v, 8'hFF);
    end
    bus(PG_HI, 8'h00, 1'b1, 1'b0, 1'b1);

    // R2 increment, with and without carry
    bus(PG_LO, 8'h10, 1'b1, 1'b0, 1'b1);
    run(37);
    check_count("R2 step", 16'h0010 + 37);
    bus(PG_HI, 8'h12, 1'b1, 1'b0, 1'b1);
    bus(PG_LO, 8'hFE, 1'b1, 1'b0, 1'b1);
    run(5);
    check_count("R2 carry", 16'h1303);

    // R3 hold while cpu_ce low, strobes ignored
    repeat (10) @(negedge clk);
    bus(PG_LO, 8'h55, 1'b1, 1'b0, 1'b0);
    check_count("R3 hold", 16'h1303);

    // R4 saturation with R10 enable clear
    bus(PG_HI, 8'h7F, 1'b1, 1'b0, 1'b1);
    bus(PG_LO, 8'hF0, 1'b1, 1'b0, 1'b1);
    run(15);
    check_count("R4 reach", 16'h7FFF);
    run(20);
    check_count("R4 no wrap", 16'h7FFF);
    check("R10 no irq", irq_n, 1);

    // R8 timing with enable set
    bus(PG_HI, 8'hFF, 1'b1, 1'b0, 1'b1);
    bus(PG_LO, 8'hFC, 1'b1, 1'b0, 1'b1);
    run(3);
    check_count("R8 at top", 16'h7FFF);
    check("R8 not yet", irq_n, 1);
    run(1);
    check("R8 fired", irq_n, 0);

    // R9 acknowledge paths
    bus(PG_LO, 8'h00, 1'b0, 1'b1, 1'b1);
    check("R9 ack read lo", irq_n, 1);
    run(1);
    check("R8 refire", irq_n, 0);
    bus(PG_HI, 8'h00, 1'b0, 1'b1, 1'b1);
    check("R9 ack read hi", irq_n, 1);
    run(1);
    bus(PG_LO, 8'hFF, 1'b1, 1'b0, 1'b1);
    check("R9 ack write lo", irq_n, 1);
    run(1);
    bus(PG_LO, 8'h00, 1'b0, 1'b1, 1'b0);
    check("R9 no ack without ce", irq_n, 0);

    // R11 foreign page: no ack, no data
    bus(5'h0C, 8'h00, 1'b0, 1'b1, 1'b1);
    check("R11 no ack", irq_n, 0);
    peek(5'h09, v); check("R11 zero read", v, 0);

    // R10 clearing enable releases the line for good
    bus(PG_HI, 8'h7F, 1'b1, 1'b0, 1'b1);
    check("R10 release", irq_n, 1);
    run(5);
    check("R10 stays", irq_n, 1);

    // R11 foreign write does not load, count keeps going
    bus(PG_HI, 8'h01, 1'b1, 1'b0, 1'b1);
    bus(PG_LO, 8'h00, 1'b1, 1'b0, 1'b1);
    bus(5'h0C, 8'h55, 1'b1, 1'b0, 1'b1);
    check_count("R11 foreign write", 16'h0101);

    // R7 write replaces increment
    bus(PG_LO, 8'h80, 1'b1, 1'b0, 1'b1);
    check_count("R7 priority", 16'h0180);

    // R1 reset mid-run
    bus(PG_HI, 8'hFF, 1'b1, 1'b0, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check_count("R1 re-reset", 0);
    peek(PG_HI, v); check("R1 enable cleared", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule